// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight synchronous interrupt source lines into an 8-bit pending-request vector for a downstream priority resolver. Each line has its own trigger-mode bit. With the bit set, the line is level-sensitive and its request simply tracks the input. With the bit clear, the line is edge-sensitive: a request is latched on a low-to-high transition and then held until the resolver acknowledges it, or until the input falls.

The trigger-mode bits sit in a byte-wide register that software writes and reads back. A parameter gives a fixed write mask, so lines that must stay edge-only ignore attempts to make them level-sensitive. Use 8'hF8 for the primary controller and 8'hDE for the secondary. A per-line pulse input forces a fresh rising edge. A synchronous initialisation strobe empties the request and previous-level state and leaves the mode register as it is.

Top module: `irq_req_latch`

## Requirements
- R1: While rst_ni is low, req_o and trig_rdata_o are both 0.
- R2: A line whose trigger bit is 1 (level mode) shows req_o equal to its input, one clock after sampling, as long as pulse and init are low.
- R3: A line whose trigger bit is 0 (edge mode) sets its req_o bit one clock after an input sample that is high when the previous stored level was low.
- R4: In edge mode, an input that stays high does not set the request again once it has been acknowledged.
- R5: In edge mode, a low input sample clears both the request bit and the stored level, one clock later.
- R6: An ack_i bit clears an edge-mode request one clock later. In level mode, ack_i has no effect.
- R7: When an edge-mode line sees ack_i and a rising edge in the same cycle, the request stays set.
- R8: A write (trig_we_i high) loads trig_wdata_i AND WR_MASK into the trigger register, readable on trig_rdata_o one clock later. Bits that the mask clears stay 0, so those lines stay edge-only.
- R9: A pulse_i bit makes its line act as high, with a stored level of low, for that cycle. An edge-mode line therefore latches a request even while its input has been held high.
- R10: init_i clears the request and stored-level registers one clock later and leaves the trigger register unchanged. An edge line held high afterwards latches a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all state |
| init_i | input | 1 | Initialisation strobe: clears request and stored level |
| irq_i | input | N_LINES | Synchronous interrupt source lines |
| pulse_i | input | N_LINES | Forced re-edge per line |
| ack_i | input | N_LINES | Acknowledge strobe per line |
| trig_we_i | input | 1 | Trigger register write enable |
| trig_wdata_i | input | N_LINES | Trigger register write data (1 = level) |
| trig_rdata_o | output | N_LINES | Trigger register read-back |
| req_o | output | N_LINES | Pending request vector |

## Verification
The assertions assume that irq_i, pulse_i, ack_i and the write strobe are already synchronous to clk_i and settle well before each rising edge. They also assume that init_i is a single-cycle strobe with the same timing. The bench meets these assumptions by changing every input only on the falling edge. The random phase keeps pulses and init strobes rare, so long edge-mode hold-high stretches occur. It also rewrites the trigger register now and then with unmasked random bytes, so that masked bits and runtime mode changes are both exercised.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  localparam int unsigned LINES_DEF = 8;
endpackage

// File: rtl/irq_trig_sel.sv
module irq_trig_sel #(
  parameter int unsigned         W    = 8,
  parameter logic [W-1:0]        MASK = 8'hF8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sel_o
);
  logic [W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (we_i) sel_q <= wdata_i & MASK;
  end

  assign sel_o = sel_q;

  // R8
  sel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (sel_o == ($past(wdata_i) & MASK)));
  // R8
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(sel_o));
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       line_i,
  input  logic       pulse_i,
  input  logic       ack_i,
  input  trig_mode_e mode_i,
  output logic       req_o
);
  logic req_q, prev_q;
  logic lvl_eff, prev_eff, rise;
  logic req_d, prev_d;

  // pulse: evaluate low first, then high
  assign lvl_eff  = line_i | pulse_i;
  assign prev_eff = prev_q & ~pulse_i;
  assign rise     = lvl_eff & ~prev_eff;

  always_comb begin
    req_d  = req_q;
    prev_d = lvl_eff;
    if (init_i) begin
      req_d  = 1'b0;
      prev_d = 1'b0;
    end else if (mode_i == TRIG_LEVEL) begin
      req_d = lvl_eff;
    end else if (!lvl_eff) begin
      req_d = 1'b0;
    end else if (rise) begin
      req_d = 1'b1;               // new edge beats ack
    end else if (ack_i) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      prev_q <= prev_d;
    end
  end

  assign req_o = req_q;

  // R2
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && mode_i == TRIG_LEVEL && !pulse_i) |=> (req_o == $past(line_i)));
  // R5
  edge_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && mode_i == TRIG_EDGE && !line_i && !pulse_i) |=> (!req_o && !prev_q));
  // R7
  edge_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && mode_i == TRIG_EDGE && line_i && !prev_q) |=> req_o);
  // R9
  pulse_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && pulse_i) |=> req_o);
  // R4
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && mode_i == TRIG_EDGE && prev_q && !pulse_i && !req_o) |=> !req_o);
  // R10
  init_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!req_o && !prev_q));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned        N_LINES = LINES_DEF,
  parameter logic [N_LINES-1:0] WR_MASK = 8'hF8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] pulse_i,
  input  logic [N_LINES-1:0] ack_i,
  input  logic               trig_we_i,
  input  logic [N_LINES-1:0] trig_wdata_i,
  output logic [N_LINES-1:0] trig_rdata_o,
  output logic [N_LINES-1:0] req_o
);
  logic [N_LINES-1:0] trig_sel;

  irq_trig_sel #(.W(N_LINES), .MASK(WR_MASK)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (trig_we_i),
    .wdata_i (trig_wdata_i),
    .sel_o   (trig_sel)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .init_i  (init_i),
      .line_i  (irq_i[g]),
      .pulse_i (pulse_i[g]),
      .ack_i   (ack_i[g]),
      .mode_i  (trig_mode_e'(trig_sel[g])),
      .req_o   (req_o[g])
    );
  end

  assign trig_rdata_o = trig_sel;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (req_o == '0 && trig_rdata_o == '0));
  // R6
  level_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && ((trig_sel & irq_i) != '0)) |=> ((req_o & $past(trig_sel & irq_i)) == $past(trig_sel & irq_i)));
endmodule

// File: tb/irq_req_latch_tb_top.sv
module irq_req_latch_tb_top;
  localparam int N = 8;
  localparam logic [N-1:0] MASK = 8'hF8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, we = 1'b0;
  logic [N-1:0] irq = '0, pulse = '0, ack = '0, wdata = '0;
  logic [N-1:0] rdata, req;

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;
  bit done = 0;
  logic [N-1:0] m_req = '0, m_prev = '0, m_sel = '0;

  always #4 clk = ~clk;

  irq_req_latch #(.N_LINES(N), .WR_MASK(MASK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .irq_i(irq), .pulse_i(pulse),
    .ack_i(ack), .trig_we_i(we), .trig_wdata_i(wdata),
    .trig_rdata_o(rdata), .req_o(req)
  );

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic void model_next(output logic [N-1:0] nr, output logic [N-1:0] np,
                                     output logic [N-1:0] ns);
    nr = m_req; np = m_prev;
    ns = we ? (wdata & MASK) : m_sel;
    for (int i = 0; i < N; i++) begin
      logic e, p;
      e = irq[i] | pulse[i];
      p = m_prev[i] & ~pulse[i];
      if (init) begin nr[i] = 0; np[i] = 0; end
      else if (m_sel[i]) begin nr[i] = e; np[i] = e; end
      else if (!e) begin nr[i] = 0; np[i] = 0; end
      else begin
        np[i] = 1;
        if (!p) nr[i] = 1;
        else if (ack[i]) nr[i] = 0;
      end
    end
  endfunction

  // inputs already driven at negedge; step one clock and compare
  task automatic cyc(string tag);
    logic [N-1:0] nr, np, ns;
    model_next(nr, np, ns);
    @(posedge clk);
    @(negedge clk);
    m_req = nr; m_prev = np; m_sel = ns;
    chk({tag, " req"}, req, m_req);
    chk({tag, " sel"}, rdata, m_sel);
    init = 0; we = 0; pulse = '0; ack = '0;
  endtask

  task automatic wr_sel(logic [N-1:0] v);
    we = 1; wdata = v; cyc("R8 write");
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 reset req", req, '0);
    chk("R1 reset sel", rdata, '0);
    rst_n = 1;
    @(negedge clk);

    // R8 masked write
    wr_sel(8'hFF);
    chk("R8 mask", rdata, 8'hF8);
    wr_sel(8'h00);

    // R3 rising edge
    irq[4] = 1; cyc("R3");
    chk("R3 set", req & 8'h10, 8'h10);
    // R6 / R4 ack, held high stays clear
    ack[4] = 1; cyc("R6 edge ack");
    chk("R6 cleared", req & 8'h10, 8'h00);
    cyc("R4"); cyc("R4");
    chk("R4 no reset", req & 8'h10, 8'h00);
    // R9 pulse on held-high line
    pulse[4] = 1; cyc("R9");
    chk("R9 re-edge", req & 8'h10, 8'h10);
    // R5 fall clears
    irq[5] = 1; cyc("R5 rise");
    irq[5] = 0; cyc("R5 fall");
    chk("R5 clear", req & 8'h20, 8'h00);
    // R7 ack with simultaneous rise
    irq[3] = 1; ack[3] = 1; cyc("R7");
    chk("R7 kept", req & 8'h08, 8'h08);
    // R2 / R6 level line
    wr_sel(8'h80);
    irq[7] = 1; cyc("R2 high");
    chk("R2 follow", req & 8'h80, 8'h80);
    ack[7] = 1; cyc("R6 level ack");
    chk("R6 level kept", req & 8'h80, 8'h80);
    irq[7] = 0; cyc("R2 low");
    chk("R2 drop", req & 8'h80, 8'h00);
    // R8 masked lines stay edge
    wr_sel(8'h87);
    chk("R8 low bits masked", rdata, 8'h80);
    irq[0] = 1; cyc("R8 edge0");
    ack[0] = 1; cyc("R8 ack0");
    chk("R8 line0 edge", req & 8'h01, 8'h00);
    // R10 init
    irq[7] = 1; pulse[1] = 1; cyc("R10 prep");
    init = 1; cyc("R10 init");
    chk("R10 req clear", req, 8'h00);
    chk("R10 sel kept", rdata, 8'h80);
    cyc("R10 after");
    chk("R10 re-latch", req & 8'h99, 8'h99);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 5) == 0) irq[i] = ~irq[i];
      ack   = N'($urandom) & N'($urandom);
      pulse = ($urandom_range(0, 7) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
      init  = ($urandom_range(0, 63) == 0);
      we    = ($urandom_range(0, 31) == 0);
      wdata = N'($urandom);
      cyc("R2 R3 R5 R6 R7 R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule